// File: doc/BRIEF.md
# Clock Ratio Measurement Unit

This block measures how fast an external oscillator clock runs compared with a recovered PLL clock. Both clocks reach the block as single-cycle enable strobes in one system clock domain. The block opens a measurement window of a fixed number of PLL-clock strobes and counts the reference-clock strobes that arrive inside it. It turns that count into an 8-bit unsigned fixed-point ratio, which it holds in a read-only result register until the next window completes.

The result has two integer bits above six fraction bits. A 64-strobe window makes the raw reference count equal to the ratio in that format. A valid flag tells the reader whether the held value can be trusted. The flag stays low from reset until the first clean window finishes. It drops as soon as the PLL reports loss of lock, and it is held low while the PLL is forced to lock without a reference. If a count does not fit the format, the result saturates and an overflow flag is raised.

Top module: `clk_ratio_meter`

## Requirements
- R1: At the end of a clean window, `ratio` equals the number of `ref_tick` strobes seen in that window, read as unsigned 2.6 fixed point: bits 7:6 are the integer part, bit 5 weighs 2^-1 and bit 0 weighs 2^-6.
- R2: 96 reference strobes in a window of 64 PLL strobes (a ratio of exactly 1.5) give `ratio` = 0x60.
- R3: During reset and after it, `ratio_valid` and `ratio_ovf` read 0 until the first clean window completes. Strobes that arrive while `rst` is high are not counted.
- R4: A window closes in the cycle that carries its 64th `pll_tick`. A `ref_tick` in that same cycle belongs to the closing window. The outputs take the new result on the next clock edge, and the next window begins in the following cycle with a zero count.
- R5: If a window's count is above 255, `ratio` becomes 0xFF and `ratio_ovf` becomes 1. A clean window with a count of 255 or less sets `ratio_ovf` to 0.
- R6: `pll_unlock` high in any cycle of a window clears `ratio_valid` on the next edge and discards that window's result. `ratio` and `ratio_ovf` keep their previous values.
- R7: While `force_lock` is high, `ratio_valid` is 0 from the next edge on. Any window that overlaps `force_lock` is discarded.
- R8: `ratio` changes only on the edge that follows a window end.
- R9: `ratio_valid` rises only on the edge that follows the end of a clean window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per external oscillator clock edge |
| pll_tick | input | 1 | One-cycle strobe per recovered PLL clock edge |
| pll_unlock | input | 1 | PLL reports loss of lock |
| force_lock | input | 1 | PLL is forced to lock with no reference clock |
| ratio | output | 8 | Measured ratio, unsigned 2.6 fixed point |
| ratio_valid | output | 1 | The held ratio is meaningful |
| ratio_ovf | output | 1 | The last accepted count saturated |

## Verification
The assertions check on every cycle that lock loss and forced lock clear the valid flag, that overflow appears only with a saturated value, that the ratio and the rising edge of the valid flag move only right after a window end, and that reset leaves both flags low. Only the bench scenarios can show that the value itself is correct. It sweeps reference counts across and beyond the 8-bit range, uses several PLL strobe spacings, puts a reference strobe in the closing cycle, and places unlock or forced lock at the start, middle and last cycle of a window. After each such event it confirms the held result is kept.

// File: rtl/ratio_pkg.sv
package ratio_pkg;
  localparam int unsigned DEF_RES_W    = 8;
  localparam int unsigned DEF_FRAC_W   = 6;
  localparam int unsigned DEF_WIN_LOG2 = 6;

  // Counter width: result width plus one saturation bit, widened when the
  // window is longer than the fraction scale.
  function automatic int unsigned count_width(input int unsigned res_w,
                                               input int unsigned win_log2,
                                               input int unsigned frac_w);
    int unsigned extra;
    extra = (win_log2 > frac_w) ? (win_log2 - frac_w) : 0;
    return res_w + 1 + extra;
  endfunction
endpackage

// File: rtl/ratio_win_ctr.sv
module ratio_win_ctr #(
  parameter int unsigned WIN_LOG2 = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic pll_tick,
  output logic win_end
);
  logic [WIN_LOG2-1:0] pll_cnt;

  assign win_end = pll_tick && (pll_cnt == {WIN_LOG2{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      pll_cnt <= '0;
    end else if (pll_tick) begin
      pll_cnt <= pll_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ratio_ref_ctr.sv
module ratio_ref_ctr #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic             win_end,
  output logic [CNT_W-1:0] total
);
  logic [CNT_W-1:0] ref_cnt;
  logic [CNT_W:0]   sum;

  // Running total including this cycle's strobe, sticky at all ones.
  always_comb begin
    sum   = {1'b0, ref_cnt} + {{CNT_W{1'b0}}, ref_tick};
    total = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || win_end) begin
      ref_cnt <= '0;
    end else begin
      ref_cnt <= total;
    end
  end
endmodule

// File: rtl/ratio_result_reg.sv
module ratio_result_reg #(
  parameter int unsigned CNT_W    = 9,
  parameter int unsigned WIN_LOG2 = 6,
  parameter int unsigned FRAC_W   = 6,
  parameter int unsigned RES_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_end,
  input  logic [CNT_W-1:0] total,
  input  logic             pll_unlock,
  input  logic             force_lock,
  output logic [RES_W-1:0] ratio,
  output logic             ratio_valid,
  output logic             ratio_ovf
);
  localparam int unsigned SW = CNT_W + FRAC_W;

  logic [SW-1:0]    scaled;
  logic             over;
  logic [RES_W-1:0] sat_val;
  logic             bad_q;
  logic             hold;

  // Scale count/window into the fixed-point grid; the variant depends on
  // whether the window is longer or shorter than the fraction scale.
  generate
    if (WIN_LOG2 >= FRAC_W) begin : g_shr
      assign scaled = SW'(total >> (WIN_LOG2 - FRAC_W));
    end else begin : g_shl
      assign scaled = SW'(total) << (FRAC_W - WIN_LOG2);
    end
  endgenerate

  assign over    = |scaled[SW-1:RES_W];
  assign sat_val = over ? {RES_W{1'b1}} : scaled[RES_W-1:0];
  assign hold    = pll_unlock || force_lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_q       <= 1'b0;
      ratio       <= '0;
      ratio_valid <= 1'b0;
      ratio_ovf   <= 1'b0;
    end else begin
      if (win_end) begin
        bad_q <= 1'b0;
      end else if (hold) begin
        bad_q <= 1'b1;
      end

      if (hold) begin
        ratio_valid <= 1'b0;
      end else if (win_end && !bad_q) begin
        ratio       <= sat_val;
        ratio_ovf   <= over;
        ratio_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_ratio_meter.sv
module clk_ratio_meter
  import ratio_pkg::*;
#(
  parameter int unsigned RES_W    = DEF_RES_W,
  parameter int unsigned FRAC_W   = DEF_FRAC_W,
  parameter int unsigned WIN_LOG2 = DEF_WIN_LOG2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic             pll_tick,
  input  logic             pll_unlock,
  input  logic             force_lock,
  output logic [RES_W-1:0] ratio,
  output logic             ratio_valid,
  output logic             ratio_ovf
);
  localparam int unsigned CNT_W = count_width(RES_W, WIN_LOG2, FRAC_W);

  logic             win_end;
  logic [CNT_W-1:0] total;

  ratio_win_ctr #(.WIN_LOG2(WIN_LOG2)) u_win (
    .clk      (clk),
    .rst      (rst),
    .pll_tick (pll_tick),
    .win_end  (win_end)
  );

  ratio_ref_ctr #(.CNT_W(CNT_W)) u_ref (
    .clk      (clk),
    .rst      (rst),
    .ref_tick (ref_tick),
    .win_end  (win_end),
    .total    (total)
  );

  ratio_result_reg #(
    .CNT_W    (CNT_W),
    .WIN_LOG2 (WIN_LOG2),
    .FRAC_W   (FRAC_W),
    .RES_W    (RES_W)
  ) u_res (
    .clk         (clk),
    .rst         (rst),
    .win_end     (win_end),
    .total       (total),
    .pll_unlock  (pll_unlock),
    .force_lock  (force_lock),
    .ratio       (ratio),
    .ratio_valid (ratio_valid),
    .ratio_ovf   (ratio_ovf)
  );
endmodule

// File: rtl/clk_ratio_meter_chk.sv
module clk_ratio_meter_chk #(
  parameter int unsigned RES_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             pll_unlock,
  input logic             force_lock,
  input logic             win_end,
  input logic [RES_W-1:0] ratio,
  input logic             ratio_valid,
  input logic             ratio_ovf
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!ratio_valid && !ratio_ovf)); // R3

  AST_UNLOCK_INVALID: assert property (@(posedge clk) disable iff (rst)
    pll_unlock |=> !ratio_valid); // R6

  AST_FORCE_INVALID: assert property (@(posedge clk) disable iff (rst)
    force_lock |=> !ratio_valid); // R7

  AST_OVF_SATURATED: assert property (@(posedge clk) disable iff (rst)
    ratio_ovf |-> (ratio == {RES_W{1'b1}})); // R5

  AST_RATIO_STABLE: assert property (@(posedge clk) disable iff (rst)
    !$stable(ratio) |-> $past(win_end)); // R8

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(ratio_valid) |-> $past(win_end)); // R9
endmodule

bind clk_ratio_meter clk_ratio_meter_chk #(.RES_W(RES_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pll_unlock  (pll_unlock),
  .force_lock  (force_lock),
  .win_end     (win_end),
  .ratio       (ratio),
  .ratio_valid (ratio_valid),
  .ratio_ovf   (ratio_ovf)
);

// File: tb/clk_ratio_meter_tb.sv
module clk_ratio_meter_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       ref_tick;
  logic       pll_tick;
  logic       pll_unlock;
  logic       force_lock;
  logic [7:0] ratio;
  logic       ratio_valid;
  logic       ratio_ovf;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] exp_ratio = 8'h00;
  logic       exp_valid = 1'b0;
  logic       exp_ovf   = 1'b0;
  bit         known     = 1'b0;

  always #2.5 clk = ~clk;

  clk_ratio_meter u_dut (
    .clk         (clk),
    .rst         (rst),
    .ref_tick    (ref_tick),
    .pll_tick    (pll_tick),
    .pll_unlock  (pll_unlock),
    .force_lock  (force_lock),
    .ratio       (ratio),
    .ratio_valid (ratio_valid),
    .ratio_ovf   (ratio_ovf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One window of 64 PLL strobes spaced 'per' cycles apart; the first 'nref'
  // cycles carry a reference strobe. unlock_at < 0 means no unlock.
  task automatic run_window(input int nref, input int per, input int unlock_at,
                            input bit frc, input string tag);
    int  span = 64 * per;
    bit  bad  = 1'b0;
    for (int c = 0; c < span; c++) begin
      pll_tick   = ((c % per) == per - 1);
      ref_tick   = (c < nref);
      pll_unlock = (c == unlock_at);
      force_lock = frc;
      @(negedge clk);
      if (pll_unlock || force_lock) begin
        exp_valid = 1'b0;
        bad       = 1'b1;
      end
      if (c == span - 1 && !bad) begin
        exp_ratio = (nref > 255) ? 8'hFF : 8'(nref);
        exp_ovf   = (nref > 255);
        exp_valid = 1'b1;
        known     = 1'b1;
      end
      if (c == span - 1) begin
        chk({tag, " ratio at window end"}, known ? ratio : 0, known ? exp_ratio : 0);
        chk("R5 overflow flag", ratio_ovf, exp_ovf);
        chk(frc ? "R7 valid" : (unlock_at >= 0 ? "R6 valid" : "R9 valid"),
            ratio_valid, exp_valid);
      end else begin
        if (known) chk("R8 ratio held mid-window", ratio, exp_ratio);
        chk(frc ? "R7 valid mid-window" :
            (known ? "R6 valid mid-window" : "R3 valid before first result"),
            ratio_valid, exp_valid);
      end
    end
    pll_tick   = 1'b0;
    ref_tick   = 1'b0;
    pll_unlock = 1'b0;
    force_lock = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst        = 1'b1;
    ref_tick   = 1'b1;
    pll_tick   = 1'b1;
    pll_unlock = 1'b0;
    force_lock = 1'b0;
    repeat (5) @(negedge clk);
    chk("R3 valid in reset", ratio_valid, 0);
    chk("R3 ovf in reset", ratio_ovf, 0);
    rst      = 1'b0;
    ref_tick = 1'b0;
    pll_tick = 1'b0;
    @(negedge clk);
    chk("R3 valid after reset", ratio_valid, 0);
    chk("R3 ovf after reset", ratio_ovf, 0);

    run_window(96, 2, -1, 1'b0, "R2");      // 1.5 -> 0x60
    run_window(64, 1, -1, 1'b0, "R4");      // tick every cycle, ratio 1.0
    run_window(128, 2, -1, 1'b0, "R4");     // ref strobe in closing cycle
    run_window(255, 5, -1, 1'b0, "R5");
    run_window(256, 5, -1, 1'b0, "R5");
    run_window(40, 3, -1, 1'b0, "R1");
    run_window(50, 5, 100, 1'b0, "R6");     // unlock mid-window
    run_window(70, 5, -1, 1'b0, "R1");
    run_window(30, 5, 319, 1'b0, "R6");     // unlock in closing cycle
    run_window(20, 5, 0, 1'b0, "R6");       // unlock in first cycle
    run_window(300, 5, -1, 1'b0, "R5");     // overflow, then discard keeps it
    run_window(10, 5, 5, 1'b0, "R6");
    run_window(33, 5, -1, 1'b0, "R1");
    run_window(80, 5, -1, 1'b1, "R7");      // forced lock
    run_window(81, 5, -1, 1'b1, "R7");
    run_window(82, 5, -1, 1'b0, "R1");

    for (int n = 0; n <= 300; n++) begin
      run_window(n, 5, -1, 1'b0, "R1");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule